// File: doc/BRIEF.md
# Serial Configuration Register Bank with Channel-Steered Writes

This block is the configuration front end of a multichannel data converter. A host talks to it over a three-wire serial port: a serial clock, an active-low chip select and a single shared data line. The shared line reaches the block as a separate input, output and output enable. Every access starts with a 16-bit instruction word, followed by one or more data bytes. The block holds chip-wide registers for port setup, identification, speed grade, power state and clock conditioning. It also holds one configuration byte per channel. Two index-mask registers decide which channels that byte reaches when it is written.

Power, clock and per-channel settings are written into a staging copy first. They reach the active outputs, which drive the rest of the chip, only when the host sets the commit bit in the transfer register. In the port-setup byte each function appears twice, mirrored about the byte centre. A host therefore gets the same result whichever bit order it uses. The block runs on a fast local clock and oversamples the serial pins. The serial clock must be several times slower than the local clock.

Top module: `spi_cfg_bank`

## Requirements
- R1: After rst_n is released, the registers read as follows. Address 0x00 reads 0x18, 0x04 reads 0x0F, 0x05 reads 0x3F, 0x08 reads 0x00, 0x09 reads 0x01 and the channel register reads 0x00. The outputs are power_mode_o=0, pdwn_standby_o=0, duty_stab_o=1 and chan_cfg_o all zero.
- R2: Instruction word layout:
  - Bit 15 is read (1) or write (0).
  - Bits 14:13 are the byte count W: 0, 1 and 2 mean 1, 2 and 3 bytes, and 3 means streaming until chip select rises.
  - Bits 12:0 are the start address.
  - Write bytes sent after the counted ones have no effect.
- R3: Bit order and address stepping:
  - In most-significant-first mode, the instruction is sent bit 15 first and each data byte bit 7 first. The address rises by one per byte.
  - In least-significant-first mode, the instruction is sent bit 0 first and each data byte bit 0 first. The address falls by one per byte.
  - The bit order is sampled on the serial clock's rising edge.
- R4: Address 0x00 is mirrored. Setting bit 6 or bit 1 selects least-significant-first mode, and the mode takes effect from the next byte. A read returns 0 in bits 7 and 0, 1 in bits 4 and 3, and the mode in bits 6 and 1.
- R5: A write to 0x00 with bit 5 or bit 2 set starts a soft reset. All registers, staged and active, return to their R1 values. The reset bits read back as 0, and the remaining bytes of that frame are ignored.
- R6: Address 0x01 always reads 0x92. Address 0x02 reads 0x30 when parameter HIGH_RATE=1 and 0x10 when it is 0, the grade code sitting in bits 6:4. Writes to either address change nothing.
- R7: The channel select mask is laid out as follows:
  - Address 0x05 bits 3:0 select channels 0 to 3, bit 4 selects channel 8 and bit 5 selects channel 9.
  - Address 0x04 bits 3:0 select channels 4 to 7.
  - Both registers read back what was written in those bits, with the other bits 0.
- R8: A write to the channel register (address LOC_ADDR, default 0x014) updates the staged byte of every selected channel and of no other channel.
- R9: A read of the channel register returns the staged byte of the lowest-numbered selected channel. It returns 0x00 when no channel is selected.
- R10: Writes to 0x08, 0x09 and the channel register change only the staged copies, and the active outputs keep their values. Writing 0xFF with bit 0 set copies every staged value to its output in one step. The commit bit reads 0 again after the next serial clock rising edge.
- R11: Staged fields and their outputs:
  - Address 0x08 bits 1:0 hold the power mode: 0 is run, 1 is full power-down, 2 is standby and 3 is reset. It drives power_mode_o.
  - Address 0x08 bit 5 sets pdwn_standby_o, where 1 means the external power-down pin requests standby.
  - Address 0x09 bit 0 drives duty_stab_o.
- R12: sdio_oe is high only during the data bytes of a read, and only while csb is low. Each read bit is valid before the serial clock rising edge on which the host samples it. The first bit is valid before the first rising edge after the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| csb | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Serial data arriving from the host |
| sdio_o | output | 1 | Serial read data towards the host |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| power_mode_o | output | 2 | Active power mode |
| pdwn_standby_o | output | 1 | Active function of the external power-down pin |
| duty_stab_o | output | 1 | Active duty-cycle stabiliser enable |
| chan_cfg_o | output | 80 | Active configuration byte of each channel, channel n at bits 8n+7:8n |

## Verification
The assertions assume the following about the inputs:
- Each high and each low phase of sclk lasts at least four local clocks, so every serial edge is seen once after the two-flop synchronisers.
- csb does not change within a few local clocks of an sclk edge.
- Frames are separated by enough idle time for the synchronised csb to return high.

The bench meets these limits. It holds each serial clock phase for eight local clocks, holds csb steady around every edge, and leaves 32 idle clocks after each frame.

The bench samples read data one phase after the preceding edge, so the synchroniser and edge-detector delays have passed before any compare.

// File: rtl/spi_cfg_pkg.sv
// Shared constants and types for the serial configuration register bank.
// Assumes a fixed ten-channel layout: eight data channels, then a frame
// clock channel (index 8) and a data clock channel (index 9).
package spi_cfg_pkg;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;
    localparam int INST_W = 16;
    localparam int N_CH   = 10;
    localparam int CNT_W  = $clog2(INST_W);

    localparam logic [ADDR_W-1:0] A_PORT   = 13'h000;
    localparam logic [ADDR_W-1:0] A_ID     = 13'h001;
    localparam logic [ADDR_W-1:0] A_GRADE  = 13'h002;
    localparam logic [ADDR_W-1:0] A_IDX_HI = 13'h004;
    localparam logic [ADDR_W-1:0] A_IDX_LO = 13'h005;
    localparam logic [ADDR_W-1:0] A_PWR    = 13'h008;
    localparam logic [ADDR_W-1:0] A_CLK    = 13'h009;
    localparam logic [ADDR_W-1:0] A_XFER   = 13'h0FF;

    localparam logic [DATA_W-1:0] CHIP_ID  = 8'h92;

    typedef enum logic [1:0] {
        PH_INST = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_t;
endpackage

// File: rtl/spi_cfg_link.sv
// Serial link engine: synchronises the serial pins to clk and detects serial
// clock rising edges. It assembles the instruction word and data bytes in
// either bit order, emits one write strobe per completed write byte, and
// serialises read data.
// Assumes: each sclk phase lasts at least four clk cycles; csb is stable near
// sclk edges.
module spi_cfg_link
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              csb,
    input  logic              sdio_i,
    input  logic              lsb_first,
    input  logic              srst,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sclk_rise,
    output logic              sdio_o,
    output logic              sdio_oe
);
    logic [1:0]        sclk_sy, csb_sy, sdi_sy;
    logic              sclk_d;
    logic              csb_s, sdi;
    phase_t            phase;
    logic [CNT_W-1:0]  cnt;
    logic [INST_W-1:0] ish, ish_nx;
    logic [DATA_W-1:0] dsh, dsh_nx;
    logic              rw_q;
    logic [1:0]        w_q, nbyte;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        bsel;

    // Two-flop synchronisers and previous-sclk register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sy <= 2'b00;
            csb_sy  <= 2'b11;
            sdi_sy  <= 2'b00;
            sclk_d  <= 1'b0;
        end else begin
            sclk_sy <= {sclk_sy[0], sclk};
            csb_sy  <= {csb_sy[0], csb};
            sdi_sy  <= {sdi_sy[0], sdio_i};
            sclk_d  <= sclk_sy[1];
        end
    end

    assign csb_s     = csb_sy[1];
    assign sdi       = sdi_sy[1];
    assign sclk_rise = sclk_sy[1] & ~sclk_d;

    // Next shift-register contents in the current bit order.
    always_comb begin
        ish_nx = lsb_first ? {sdi, ish[INST_W-1:1]} : {ish[INST_W-2:0], sdi};
        dsh_nx = lsb_first ? {sdi, dsh[DATA_W-1:1]} : {dsh[DATA_W-2:0], sdi};
    end

    // Frame sequencer: instruction, data bytes, then idle until csb rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_INST;
            cnt     <= '0;
            ish     <= '0;
            dsh     <= '0;
            rw_q    <= 1'b0;
            w_q     <= 2'b00;
            nbyte   <= 2'b00;
            addr_q  <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (csb_s) begin
                phase <= PH_INST;
                cnt   <= '0;
            end else if (srst) begin
                phase <= PH_DONE;
            end else if (sclk_rise) begin
                case (phase)
                    PH_INST: begin
                        ish <= ish_nx;
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(INST_W-1)) begin
                            rw_q   <= ish_nx[INST_W-1];
                            w_q    <= ish_nx[INST_W-2:INST_W-3];
                            addr_q <= ish_nx[ADDR_W-1:0];
                            nbyte  <= 2'b00;
                            cnt    <= '0;
                            phase  <= PH_DATA;
                        end
                    end
                    PH_DATA: begin
                        dsh <= dsh_nx;
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(DATA_W-1)) begin
                            cnt <= '0;
                            if (!rw_q) begin
                                wr_en   <= 1'b1;
                                wr_addr <= addr_q;
                                wr_data <= dsh_nx;
                            end
                            addr_q <= lsb_first ? addr_q - 1'b1 : addr_q + 1'b1;
                            nbyte  <= nbyte + 1'b1;
                            if (w_q != 2'b11 && nbyte == w_q)
                                phase <= PH_DONE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read serialiser: pick the bit for the current position and order.
    assign bsel    = lsb_first ? cnt[2:0] : 3'd7 - cnt[2:0];
    assign rd_addr = addr_q;
    assign sdio_o  = rd_data[bsel];
    assign sdio_oe = (phase == PH_DATA) & rw_q & ~csb;

    AST_OE_ONLY_CSB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        csb |-> !sdio_oe);                                   // R12
    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);                                   // R2
    AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE) |-> !sdio_oe);                    // R2
endmodule

// File: rtl/spi_cfg_chan.sv
// One channel slice: a staged configuration byte, written only when this
// channel is selected, and an active byte loaded on commit.
// Assumes srst, wr_en and commit are single-cycle strobes in the clk domain.
module spi_cfg_chan
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              wr_en,
    input  logic              sel,
    input  logic              commit,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] stg_o,
    output logic [DATA_W-1:0] act_o
);
    // Staged and active byte, both restored by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            stg_o <= '0;
            act_o <= '0;
        end else begin
            if (wr_en && sel) stg_o <= wr_data;
            if (commit)       act_o <= stg_o;
        end
    end

    AST_LOCAL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel && !srst) |=> $stable(stg_o));        // R8
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !srst) |=> $stable(act_o));              // R10
endmodule

// File: rtl/spi_cfg_regs.sv
// Register file: chip-wide registers, the channel select mask, staged and
// active power/clock fields, the transfer register and the per-channel slices.
// Assumes write strobes come one at a time from the link engine.
module spi_cfg_regs
    import spi_cfg_pkg::*;
#(
    parameter bit                HIGH_RATE = 1'b1,
    parameter logic [ADDR_W-1:0] LOC_ADDR  = 13'h014
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic                     sclk_rise,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     lsb_first,
    output logic                     srst,
    output logic [1:0]               power_mode_o,
    output logic                     pdwn_standby_o,
    output logic                     duty_stab_o,
    output logic [N_CH*DATA_W-1:0]   chan_cfg_o
);
    localparam logic [DATA_W-1:0] GRADE_BYTE = HIGH_RATE ? 8'h30 : 8'h10;

    logic [N_CH-1:0]   mask_q;
    logic [1:0]        pm_stg;
    logic              pdsb_stg, dcs_stg, xfer_q;
    logic              commit, loc_wr;
    logic [DATA_W-1:0] loc_stg [N_CH];
    logic [DATA_W-1:0] loc_rd;

    // Strobe decode for soft reset, commit and channel writes.
    assign srst   = wr_en && (wr_addr == A_PORT) && (wr_data[5] || wr_data[2]);
    assign commit = wr_en && (wr_addr == A_XFER) && wr_data[0];
    assign loc_wr = wr_en && (wr_addr == LOC_ADDR);

    // Chip-wide registers with staged/active pairs and self-clearing transfer bit.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            lsb_first      <= 1'b0;
            mask_q         <= '1;
            pm_stg         <= 2'b00;
            pdsb_stg       <= 1'b0;
            dcs_stg        <= 1'b1;
            xfer_q         <= 1'b0;
            power_mode_o   <= 2'b00;
            pdwn_standby_o <= 1'b0;
            duty_stab_o    <= 1'b1;
        end else begin
            if (sclk_rise) xfer_q <= 1'b0;
            if (wr_en) begin
                case (wr_addr)
                    A_PORT:   lsb_first <= wr_data[6] | wr_data[1];
                    A_IDX_HI: mask_q[7:4] <= wr_data[3:0];
                    A_IDX_LO: begin
                        mask_q[3:0] <= wr_data[3:0];
                        mask_q[8]   <= wr_data[4];
                        mask_q[9]   <= wr_data[5];
                    end
                    A_PWR: begin
                        pm_stg   <= wr_data[1:0];
                        pdsb_stg <= wr_data[5];
                    end
                    A_CLK:  dcs_stg <= wr_data[0];
                    A_XFER: xfer_q  <= wr_data[0];
                    default: ;
                endcase
            end
            if (commit) begin
                power_mode_o   <= pm_stg;
                pdwn_standby_o <= pdsb_stg;
                duty_stab_o    <= dcs_stg;
            end
        end
    end

    // One slice per channel, steered by its mask bit.
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        spi_cfg_chan u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .srst    (srst),
            .wr_en   (loc_wr),
            .sel     (mask_q[g]),
            .commit  (commit),
            .wr_data (wr_data),
            .stg_o   (loc_stg[g]),
            .act_o   (chan_cfg_o[g*DATA_W +: DATA_W])
        );
    end

    // Channel read-back: lowest selected channel wins, zero if none.
    always_comb begin
        loc_rd = '0;
        for (int i = N_CH - 1; i >= 0; i--)
            if (mask_q[i]) loc_rd = loc_stg[i];
    end

    // Read multiplexer over the address map.
    always_comb begin
        case (rd_addr)
            A_PORT:   rd_data = {1'b0, lsb_first, 1'b0, 1'b1, 1'b1, 1'b0, lsb_first, 1'b0};
            A_ID:     rd_data = CHIP_ID;
            A_GRADE:  rd_data = GRADE_BYTE;
            A_IDX_HI: rd_data = {4'b0000, mask_q[7:4]};
            A_IDX_LO: rd_data = {2'b00, mask_q[9:8], mask_q[3:0]};
            A_PWR:    rd_data = {2'b00, pdsb_stg, 3'b000, pm_stg};
            A_CLK:    rd_data = {7'b0, dcs_stg};
            A_XFER:   rd_data = {7'b0, xfer_q};
            LOC_ADDR: rd_data = loc_rd;
            default:  rd_data = '0;
        endcase
    end

    AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (mask_q == '1 && !lsb_first && duty_stab_o && power_mode_o == 2'b00)); // R5
    AST_XFER_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_q && sclk_rise && !wr_en) |=> !xfer_q);        // R10
    AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (power_mode_o == $past(pm_stg) && duty_stab_o == $past(dcs_stg))); // R10
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !srst) |=> ($stable(power_mode_o) && $stable(duty_stab_o)));      // R10
endmodule

// File: rtl/spi_cfg_bank.sv
// Top of the serial configuration register bank: joins the link engine to
// the register file. Assumes clk runs at least eight times faster than sclk.
module spi_cfg_bank
    import spi_cfg_pkg::*;
#(
    parameter bit                HIGH_RATE = 1'b1,
    parameter logic [ADDR_W-1:0] LOC_ADDR  = 13'h014
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk,
    input  logic                   csb,
    input  logic                   sdio_i,
    output logic                   sdio_o,
    output logic                   sdio_oe,
    output logic [1:0]             power_mode_o,
    output logic                   pdwn_standby_o,
    output logic                   duty_stab_o,
    output logic [N_CH*DATA_W-1:0] chan_cfg_o
);
    logic              lsb_first, srst, wr_en, sclk_rise;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;

    spi_cfg_link u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .csb       (csb),
        .sdio_i    (sdio_i),
        .lsb_first (lsb_first),
        .srst      (srst),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sclk_rise (sclk_rise),
        .sdio_o    (sdio_o),
        .sdio_oe   (sdio_oe)
    );

    spi_cfg_regs #(
        .HIGH_RATE (HIGH_RATE),
        .LOC_ADDR  (LOC_ADDR)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .rd_addr        (rd_addr),
        .sclk_rise      (sclk_rise),
        .rd_data        (rd_data),
        .lsb_first      (lsb_first),
        .srst           (srst),
        .power_mode_o   (power_mode_o),
        .pdwn_standby_o (pdwn_standby_o),
        .duty_stab_o    (duty_stab_o),
        .chan_cfg_o     (chan_cfg_o)
    );
endmodule

// File: tb/spi_cfg_bank_test.sv
module spi_cfg_bank_test;
    localparam int HALF = 8;
    localparam logic [12:0] LOC = 13'h014;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, csb = 1'b1, sdio_i = 1'b0;
    logic sdio_o, sdio_oe, pdsb, dcs;
    logic [1:0]  pm;
    logic [79:0] cfg;

    int checks = 0, fails = 0;
    bit lsb_mode = 1'b0, oe_bad = 1'b0, oe_miss = 1'b0, done = 1'b0;
    logic [7:0] tx [4];
    logic [7:0] rx [4];

    always #4 clk = ~clk;

    spi_cfg_bank uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .power_mode_o(pm),
        .pdwn_standby_o(pdsb), .duty_stab_o(dcs), .chan_cfg_o(cfg)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial frame: instruction, then n bytes from tx (writes) or into rx (reads).
    task automatic frame(input bit rw, input logic [1:0] w, input logic [12:0] a, input int n);
        logic [15:0] ins;
        ins = {rw, w, a};
        csb = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 16; i++) begin
            sdio_i = lsb_mode ? ins[i] : ins[15-i];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        for (int b = 0; b < n; b++) begin
            rx[b] = 8'h00;
            for (int i = 0; i < 8; i++) begin
                sdio_i = lsb_mode ? tx[b][i] : tx[b][7-i];
                wait_clk(HALF);
                if (rw) begin
                    if (lsb_mode) rx[b][i] = sdio_o; else rx[b][7-i] = sdio_o;
                    if (!sdio_oe) oe_miss = 1'b1;
                end else if (sdio_oe) oe_bad = 1'b1;
                sclk = 1'b1;
                wait_clk(HALF);
                sclk = 1'b0;
            end
        end
        wait_clk(HALF);
        csb = 1'b1;
        wait_clk(1);
        if (sdio_oe) oe_bad = 1'b1;
        wait_clk(4*HALF);
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        tx[0] = d;
        frame(1'b0, 2'b00, a, 1);
    endtask

    task automatic chk_rd(input string req, input logic [12:0] a, input logic [7:0] exp);
        tx[0] = 8'h00;
        frame(1'b1, 2'b00, a, 1);
        chk(req, {24'h0, rx[0]}, {24'h0, exp});
    endtask

    task automatic commit();
        wr(13'h0FF, 8'h01);
    endtask

    // Mask bytes that select exactly one channel, per the R7 layout.
    function automatic logic [7:0] hi_sel(input int ch);
        return (ch >= 4 && ch <= 7) ? 8'(1 << (ch - 4)) : 8'h00;
    endfunction
    function automatic logic [7:0] lo_sel(input int ch);
        if (ch < 4)  return 8'(1 << ch);
        if (ch == 8) return 8'h10;
        if (ch == 9) return 8'h20;
        return 8'h00;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : main
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1 reset state
        chk_rd("R1 port", 13'h000, 8'h18);
        chk_rd("R1 idx_hi", 13'h004, 8'h0F);
        chk_rd("R1 idx_lo", 13'h005, 8'h3F);
        chk_rd("R1 pwr", 13'h008, 8'h00);
        chk_rd("R1 clk", 13'h009, 8'h01);
        chk_rd("R1 local", LOC, 8'h00);
        chk("R1 outputs", {26'h0, pm, pdsb, dcs}, 32'h1);
        chk("R1 chan_cfg", {31'h0, cfg == 80'h0}, 32'h1);

        // R6 identification registers are read-only
        chk_rd("R6 id", 13'h001, 8'h92);
        chk_rd("R6 grade", 13'h002, 8'h30);
        wr(13'h001, 8'h55);
        wr(13'h002, 8'hFF);
        chk_rd("R6 id after write", 13'h001, 8'h92);
        chk_rd("R6 grade after write", 13'h002, 8'h30);

        // R10 staging then commit
        wr(13'h008, 8'h21);
        chk_rd("R10 pwr staged", 13'h008, 8'h21);
        wr(13'h009, 8'h00);
        chk_rd("R10 clk staged", 13'h009, 8'h00);
        chk("R10 outputs unchanged", {26'h0, pm, pdsb, dcs}, 32'h1);
        commit();
        chk("R10 outputs committed", {26'h0, pm, pdsb, dcs}, {26'h0, 2'b01, 1'b1, 1'b0});
        chk_rd("R10 xfer self-clear", 13'h0FF, 8'h00);

        // R11 power mode sweep
        for (int m = 0; m < 4; m++) begin
            logic [1:0] mm;
            mm = 2'(m);
            wr(13'h008, {2'b00, mm[0], 3'b000, mm});
            commit();
            chk("R11 power mode", {30'h0, pm}, {30'h0, mm});
            chk("R11 pin function", {31'h0, pdsb}, {31'h0, mm[0]});
        end
        wr(13'h009, 8'h01);
        commit();
        chk("R11 duty stabiliser", {31'h0, dcs}, 32'h1);

        // R7/R8 one channel at a time
        for (int ch = 0; ch < 10; ch++) begin
            wr(13'h004, hi_sel(ch));
            wr(13'h005, lo_sel(ch));
            wr(LOC, 8'(8'h40 + ch));
            chk_rd("R9 single select", LOC, 8'(8'h40 + ch));
        end
        chk_rd("R7 idx_hi", 13'h004, 8'h00);
        chk_rd("R7 idx_lo", 13'h005, 8'h20);
        chk("R10 channels before commit", {31'h0, cfg == 80'h0}, 32'h1);
        commit();
        for (int ch = 0; ch < 10; ch++)
            chk("R8 per-channel value", {24'h0, cfg[ch*8 +: 8]}, 32'(8'h40 + ch));

        // R8/R9 no channel selected
        wr(13'h005, 8'h00);
        wr(LOC, 8'hEE);
        chk_rd("R9 none selected", LOC, 8'h00);
        commit();
        for (int ch = 0; ch < 10; ch++)
            chk("R8 unselected unchanged", {24'h0, cfg[ch*8 +: 8]}, 32'(8'h40 + ch));

        // R9 lowest selected wins
        wr(13'h004, 8'h04);
        wr(13'h005, 8'h08);
        chk_rd("R9 lowest of 3,6", LOC, 8'h43);
        wr(13'h004, 8'h00);
        wr(13'h005, 8'h30);
        chk_rd("R9 lowest of 8,9", LOC, 8'h48);

        // R2/R3 streaming, MSB-first increments
        tx[0] = 8'h03;
        tx[1] = 8'h21;
        frame(1'b0, 2'b01, 13'h004, 2);
        chk_rd("R3 stream wr first", 13'h004, 8'h03);
        chk_rd("R3 stream wr second", 13'h005, 8'h21);
        tx[0] = 8'h00; tx[1] = 8'h00; tx[2] = 8'h00;
        frame(1'b1, 2'b11, 13'h000, 3);
        chk("R3 stream rd 0", {24'h0, rx[0]}, 32'h18);
        chk("R3 stream rd 1", {24'h0, rx[1]}, 32'h92);
        chk("R3 stream rd 2", {24'h0, rx[2]}, 32'h30);
        tx[0] = 8'h02;
        tx[1] = 8'h00;
        frame(1'b0, 2'b00, 13'h008, 2);
        chk_rd("R2 counted byte", 13'h008, 8'h02);
        chk_rd("R2 extra byte ignored", 13'h009, 8'h01);

        // R3/R4 LSB-first via bit 6
        wr(13'h000, 8'h40);
        lsb_mode = 1'b1;
        chk_rd("R4 lsb via bit6", 13'h000, 8'h5A);
        tx[0] = 8'h00; tx[1] = 8'h00; tx[2] = 8'h00;
        frame(1'b1, 2'b10, 13'h002, 3);
        chk("R3 lsb dec 0", {24'h0, rx[0]}, 32'h30);
        chk("R3 lsb dec 1", {24'h0, rx[1]}, 32'h92);
        chk("R3 lsb dec 2", {24'h0, rx[2]}, 32'h5A);
        tx[0] = 8'h3F;
        tx[1] = 8'h0F;
        frame(1'b0, 2'b01, 13'h005, 2);
        chk_rd("R3 lsb wr 05", 13'h005, 8'h3F);
        chk_rd("R3 lsb wr 04", 13'h004, 8'h0F);
        wr(13'h000, 8'h18);
        lsb_mode = 1'b0;
        chk_rd("R4 back to msb", 13'h000, 8'h18);
        wr(13'h000, 8'h02);
        lsb_mode = 1'b1;
        chk_rd("R4 lsb via bit1", 13'h000, 8'h5A);
        wr(13'h000, 8'h18);
        lsb_mode = 1'b0;

        // R5 soft reset via bit 2, then via bit 5
        wr(13'h005, 8'h01);
        wr(13'h000, 8'h04);
        chk_rd("R5 port after srst", 13'h000, 8'h18);
        chk_rd("R5 idx_lo after srst", 13'h005, 8'h3F);
        chk_rd("R5 pwr after srst", 13'h008, 8'h00);
        chk_rd("R5 local after srst", LOC, 8'h00);
        chk("R5 outputs after srst", {26'h0, pm, pdsb, dcs}, 32'h1);
        chk("R5 channels after srst", {31'h0, cfg == 80'h0}, 32'h1);
        wr(13'h004, 8'h01);
        wr(13'h000, 8'h20);
        chk_rd("R5 bit5 srst", 13'h004, 8'h0F);

        // R12 drive enable behaviour over the whole run
        chk("R12 oe never on during writes or idle", {31'h0, oe_bad}, 32'h0);
        chk("R12 oe on during read bytes", {31'h0, oe_miss}, 32'h0);
        chk("R12 oe idle", {31'h0, sdio_oe}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule